// File: doc/BRIEF.md
# Reset Configuration Capture Unit

This unit puts its host into a known idle state during an active-low reset and takes system options from the data bus when reset ends. While reset is low it raises a bus-isolation output. External logic uses that output to drive the option byte onto the bus. The unit also holds clear strobes on the translation enable, on every breakpoint enable and on the access-level-check field. Only the low byte of the bus is used. The value captured is the one present on the last clock edge that sees reset low, and it takes effect on the first clock edge that sees reset high.

The captured byte is decoded into static fields: slave port size, extra decision delay in half-clocks, same-edge strobe mode for table searches, early exception startup and cache-inhibit enable. A sticky flag reports a byte whose check bit was low. The unit answers slave accesses with an acknowledge code that matches the port size. It answers a breakpoint-acknowledge cycle with a bus error when the addressed breakpoint is disabled. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Lines that are left floating are taken as pulled high. An all-ones byte therefore selects every default.

Top module: `rstcfg_capture`

## Requirements
- R1: `bus_iso_o` is high whenever `rst_n` is low and low whenever `rst_n` is high.
- R2: The configuration comes from `data_i[7:0]` as sampled on the last rising clock edge with `rst_n` low. It is visible after the first rising edge with `rst_n` high. `data_i[31:8]` has no effect.
- R3: `tc_en_clr_o`, every bit of `bkpt_en_clr_o` (8 bits) and `alc_clr_o` are high in each cycle that follows an edge seeing `rst_n` low, and low in every cycle that follows an edge seeing it high.
- R4: Byte bits 2:1 choose `size_o`: 00 gives 0 (8-bit), 01 gives 1 (16-bit), and 10 or 11 give 2 (32-bit).
- R5: An edge with `slv_req_i` high and `rst_n` high makes `slv_ack_o` 2'b01 for 8-bit, 2'b10 for 16-bit or 2'b11 for 32-bit in the next cycle. Otherwise `slv_ack_o` is 2'b00.
- R6: Byte bits 4:3 with value v give `extra_dly_o` = 3 - v half-clocks, so 11 means no extra delay.
- R7: `same_edge_o` is 1 exactly when byte bit 5 was 0.
- R8: `early_start_o` equals byte bit 6.
- R9: `cinh_en_o` equals byte bit 7.
- R10: An edge with `bk_req_i` high, `rst_n` high and `bkpt_en_i[bk_idx_i]` low makes `berr_o` high in the next cycle. If that enable is high, or if no request is present, `berr_o` is low.
- R11: `cfg_err_o` becomes 1 when the committed byte has bit 0 low and 0 when bit 0 is high. It keeps its value through later reset periods and changes only at a commit.
- R12: After the commit, changes on `data_i` leave every configuration output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin; its release commits the configuration |
| data_i | input | 32 | Data bus; only bits 7:0 are captured |
| slv_req_i | input | 1 | Slave access strobe |
| bk_req_i | input | 1 | Breakpoint-acknowledge cycle strobe |
| bk_idx_i | input | 3 | Breakpoint number being acknowledged |
| bkpt_en_i | input | 8 | Current breakpoint enable bits |
| bus_iso_o | output | 1 | Data-bus isolation, high during reset |
| size_o | output | 2 | Port size: 0 = 8, 1 = 16, 2 = 32 bits |
| slv_ack_o | output | 2 | Slave acknowledge code |
| extra_dly_o | output | 2 | Extra decision delay in half-clocks |
| same_edge_o | output | 1 | Table-search strobes follow the translation edge |
| early_start_o | output | 1 | Early exception startup enabled |
| cinh_en_o | output | 1 | Cache-inhibit on self-initiated cycles |
| cfg_err_o | output | 1 | Sticky check-bit error |
| tc_en_clr_o | output | 1 | Clear strobe for the translation enable |
| bkpt_en_clr_o | output | 8 | Clear strobes for the breakpoint enables |
| alc_clr_o | output | 1 | Clear strobe for the access-level-check field |
| berr_o | output | 1 | Bus error answering a disabled breakpoint acknowledge |

## Verification
The assertions check the following on every cycle:
- the clear strobes follow reset;
- the configuration stays frozen outside a commit;
- a bus error follows a disabled breakpoint acknowledge, and never appears without a request;
- the slave acknowledge appears exactly one cycle after a request.

Only the bench scenarios can show the rest:
- that each bit pattern decodes into the right field values;
- that the last byte sampled during reset is the one kept;
- that the upper bus bits and later bus traffic are ignored;
- that the error flag survives a reset period.

// File: rtl/rstcfg_pkg.sv
package rstcfg_pkg;

  typedef enum logic [1:0] {
    PS_8  = 2'd0,
    PS_16 = 2'd1,
    PS_32 = 2'd2
  } psize_e;

  typedef struct packed {
    psize_e     size;
    logic [1:0] dly;
    logic       same_edge;
    logic       early;
    logic       cinh;
    logic       err;
  } cfg_t;

  // Positions of the option fields inside the captured byte
  localparam int unsigned POS_CHK   = 0;
  localparam int unsigned POS_SIZE  = 1;
  localparam int unsigned POS_DLY   = 3;
  localparam int unsigned POS_EDGE  = 5;
  localparam int unsigned POS_EARLY = 6;
  localparam int unsigned POS_CINH  = 7;

  function automatic logic [1:0] ack_code(psize_e s);
    case (s)
      PS_8:    ack_code = 2'b01;
      PS_16:   ack_code = 2'b10;
      default: ack_code = 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/rstcfg_sampler.sv
module rstcfg_sampler #(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [CFG_W-1:0] raw_o
);
  logic [CFG_W-1:0] shadow_q;
  logic [CFG_W-1:0] raw_q;
  logic             in_rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= cfg_in;
      in_rst_q <= 1'b1;
    end else begin
      in_rst_q <= 1'b0;
      if (in_rst_q) raw_q <= shadow_q;
    end
  end

  assign raw_o = raw_q;

  // R12
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rst_q |=> $stable(raw_q));

endmodule

// File: rtl/rstcfg_decode.sv
module rstcfg_decode
  import rstcfg_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  logic [CFG_W-1:0] raw_i,
  output cfg_t             cfg_o
);
  logic [1:0] size_bits;
  logic [1:0] dly_bits;

  assign size_bits = raw_i[POS_SIZE +: 2];
  assign dly_bits  = raw_i[POS_DLY +: 2];

  always_comb begin
    case (size_bits)
      2'b00:   cfg_o.size = PS_8;
      2'b01:   cfg_o.size = PS_16;
      default: cfg_o.size = PS_32;
    endcase
    cfg_o.dly       = 2'd3 - dly_bits;
    cfg_o.same_edge = ~raw_i[POS_EDGE];
    cfg_o.early     = raw_i[POS_EARLY];
    cfg_o.cinh      = raw_i[POS_CINH];
    cfg_o.err       = ~raw_i[POS_CHK];
  end

endmodule

// File: rtl/rstcfg_clear.sv
module rstcfg_clear #(
  parameter int unsigned NUM_BKPT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                tc_clr_o,
  output logic [NUM_BKPT-1:0] bkpt_clr_o,
  output logic                alc_clr_o
);
  logic clr_q;

  always_ff @(posedge clk) clr_q <= ~rst_n;

  assign tc_clr_o  = clr_q;
  assign alc_clr_o = clr_q;

  for (genvar g = 0; g < NUM_BKPT; g++) begin : g_bk
    assign bkpt_clr_o[g] = clr_q;
  end

  // R3
  clr_follow_chk: assert property (@(posedge clk)
    !rst_n |=> (tc_clr_o && alc_clr_o && (&bkpt_clr_o)));

  // R3
  clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (tc_clr_o || alc_clr_o || (|bkpt_clr_o)) == !rst_n);

endmodule

// File: rtl/rstcfg_resp.sv
module rstcfg_resp
  import rstcfg_pkg::*;
#(
  parameter int unsigned NUM_BKPT = 8,
  localparam int unsigned IDX_W   = (NUM_BKPT > 1) ? $clog2(NUM_BKPT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  psize_e              size_i,
  input  logic                slv_req_i,
  input  logic                bk_req_i,
  input  logic [IDX_W-1:0]    bk_idx_i,
  input  logic [NUM_BKPT-1:0] bkpt_en_i,
  output logic [1:0]          slv_ack_o,
  output logic                berr_o
);
  logic [1:0] ack_q;
  logic       berr_q;

  always_ff @(posedge clk) begin
    ack_q  <= (rst_n && slv_req_i) ? ack_code(size_i) : 2'b00;
    berr_q <= rst_n && bk_req_i && !bkpt_en_i[bk_idx_i];
  end

  assign slv_ack_o = ack_q;
  assign berr_o    = berr_q;

  // R10
  berr_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_req_i && !bkpt_en_i[bk_idx_i]) |=> berr_o);

  // R10
  berr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    berr_o |-> $past(bk_req_i));

  // R5
  ack_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_req_i |=> (slv_ack_o != 2'b00));

  // R5
  ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slv_req_i |=> (slv_ack_o == 2'b00));

endmodule

// File: rtl/rstcfg_capture.sv
module rstcfg_capture
  import rstcfg_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned NUM_BKPT = 8,
  localparam int unsigned IDX_W   = (NUM_BKPT > 1) ? $clog2(NUM_BKPT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                slv_req_i,
  input  logic                bk_req_i,
  input  logic [IDX_W-1:0]    bk_idx_i,
  input  logic [NUM_BKPT-1:0] bkpt_en_i,
  output logic                bus_iso_o,
  output logic [1:0]          size_o,
  output logic [1:0]          slv_ack_o,
  output logic [1:0]          extra_dly_o,
  output logic                same_edge_o,
  output logic                early_start_o,
  output logic                cinh_en_o,
  output logic                cfg_err_o,
  output logic                tc_en_clr_o,
  output logic [NUM_BKPT-1:0] bkpt_en_clr_o,
  output logic                alc_clr_o,
  output logic                berr_o
);
  logic [CFG_W-1:0] raw;
  cfg_t             cfg;
  logic             unused_hi;

  assign unused_hi = ^data_i[DATA_W-1:CFG_W];
  assign bus_iso_o = ~rst_n;

  rstcfg_sampler #(.CFG_W(CFG_W)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_in (data_i[CFG_W-1:0]),
    .raw_o  (raw)
  );

  rstcfg_decode #(.CFG_W(CFG_W)) u_decode (
    .raw_i (raw),
    .cfg_o (cfg)
  );

  rstcfg_clear #(.NUM_BKPT(NUM_BKPT)) u_clear (
    .clk        (clk),
    .rst_n      (rst_n),
    .tc_clr_o   (tc_en_clr_o),
    .bkpt_clr_o (bkpt_en_clr_o),
    .alc_clr_o  (alc_clr_o)
  );

  rstcfg_resp #(.NUM_BKPT(NUM_BKPT)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .size_i    (cfg.size),
    .slv_req_i (slv_req_i),
    .bk_req_i  (bk_req_i),
    .bk_idx_i  (bk_idx_i),
    .bkpt_en_i (bkpt_en_i),
    .slv_ack_o (slv_ack_o),
    .berr_o    (berr_o)
  );

  assign size_o        = cfg.size;
  assign extra_dly_o   = cfg.dly;
  assign same_edge_o   = cfg.same_edge;
  assign early_start_o = cfg.early;
  assign cinh_en_o     = cfg.cinh;
  assign cfg_err_o     = cfg.err;

  // R1
  iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |-> !bus_iso_o);

endmodule

// File: tb/rstcfg_capture_tb.sv
module rstcfg_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data = 32'hFFFF_FFFF;
  logic        slv_req = 1'b0;
  logic        bk_req = 1'b0;
  logic [2:0]  bk_idx = 3'd0;
  logic [7:0]  bkpt_en = 8'h00;
  logic        bus_iso, same_edge, early, cinh, cerr, tc_clr, alc_clr, berr;
  logic [1:0]  size, ack, dly;
  logic [7:0]  bk_clr;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rstcfg_capture u_dut (
    .clk(clk), .rst_n(rst_n), .data_i(data), .slv_req_i(slv_req),
    .bk_req_i(bk_req), .bk_idx_i(bk_idx), .bkpt_en_i(bkpt_en),
    .bus_iso_o(bus_iso), .size_o(size), .slv_ack_o(ack),
    .extra_dly_o(dly), .same_edge_o(same_edge), .early_start_o(early),
    .cinh_en_o(cinh), .cfg_err_o(cerr), .tc_en_clr_o(tc_clr),
    .bkpt_en_clr_o(bk_clr), .alc_clr_o(alc_clr), .berr_o(berr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_size(input logic [7:0] b);
    return (b[2:1] == 2'b00) ? 2'd0 : (b[2:1] == 2'b01) ? 2'd1 : 2'd2;
  endfunction

  // Hold reset with byte b (upper bits hi), release with garbage on the bus
  task automatic apply_reset(input logic [7:0] b, input logic [23:0] hi);
    @(negedge clk);
    rst_n = 1'b0;
    data  = {hi, 8'h5A};
    @(negedge clk);
    data  = {hi, b};
    repeat (2) @(negedge clk);
    check("R1 iso in reset", {31'd0, bus_iso}, 32'd1);
    check("R3 clears in reset", {21'd0, tc_clr, bk_clr, alc_clr}, {21'd0, 1'b1, 8'hFF, 1'b1});
    rst_n = 1'b1;
    data  = ~{hi, b};
    @(negedge clk);
  endtask

  task automatic check_cfg(input logic [7:0] b);
    check("R4 size", {30'd0, size}, {30'd0, exp_size(b)});
    check("R6 delay", {30'd0, dly}, {30'd0, 2'd3 - b[4:3]});
    check("R7 same edge", {31'd0, same_edge}, {31'd0, ~b[5]});
    check("R8 early", {31'd0, early}, {31'd0, b[6]});
    check("R9 cinh", {31'd0, cinh}, {31'd0, b[7]});
    check("R11 cfg err", {31'd0, cerr}, {31'd0, ~b[0]});
  endtask

  task automatic t_defaults();
    apply_reset(8'hFF, 24'h000000);
    check("R1 iso released", {31'd0, bus_iso}, 32'd0);
    check("R3 clears released", {21'd0, tc_clr, bk_clr, alc_clr}, 32'd0);
    check_cfg(8'hFF);
  endtask

  task automatic t_patterns();
    logic [7:0] pats [4] = '{8'h00, 8'hA5, 8'h4B, 8'h33};
    for (int i = 0; i < 4; i++) begin
      apply_reset(pats[i], 24'hC3C3C3 ^ 24'(i));
      check_cfg(pats[i]); // R2 upper bits ignored, last low-cycle byte kept
    end
  endtask

  task automatic t_slave_ack();
    logic [7:0] bs [4] = '{8'hF9, 8'hFB, 8'hFD, 8'hFF};
    logic [1:0] ex [4] = '{2'b01, 2'b10, 2'b11, 2'b11};
    for (int i = 0; i < 4; i++) begin
      apply_reset(bs[i], 24'h0);
      slv_req = 1'b1;
      @(negedge clk);
      check("R5 ack", {30'd0, ack}, {30'd0, ex[i]});
      slv_req = 1'b0;
      @(negedge clk);
      check("R5 ack idle", {30'd0, ack}, 32'd0);
    end
  endtask

  task automatic t_berr();
    apply_reset(8'hFF, 24'h0);
    bkpt_en = 8'b0010_0000;
    bk_idx  = 3'd5;
    bk_req  = 1'b1;
    @(negedge clk);
    check("R10 enabled no berr", {31'd0, berr}, 32'd0);
    bk_idx = 3'd2;
    @(negedge clk);
    check("R10 disabled berr", {31'd0, berr}, 32'd1);
    bk_req = 1'b0;
    @(negedge clk);
    check("R10 no request", {31'd0, berr}, 32'd0);
    bkpt_en = 8'h00;
  endtask

  task automatic t_sticky();
    apply_reset(8'hFE, 24'h0);
    check("R11 set", {31'd0, cerr}, 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    data  = 32'hFF;
    repeat (3) @(negedge clk);
    check("R11 held in reset", {31'd0, cerr}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 cleared", {31'd0, cerr}, 32'd0);
  endtask

  task automatic t_frozen();
    apply_reset(8'h2D, 24'h0);
    for (int i = 0; i < 6; i++) begin
      data = 32'h1234_5600 + 32'(i * 37);
      @(negedge clk);
    end
    check_cfg(8'h2D); // R12
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_defaults();
    t_patterns();
    t_slave_ack();
    t_berr();
    t_sticky();
    t_frozen();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule